// File: doc/BRIEF.md
# Ten-Instruction Accumulator Core

This block is a small accumulator machine. It holds two registers, an accumulator and one general-purpose register, and has a data input bus and a registered data output bus. On every clock edge it executes the 4-bit opcode presented on its instruction input. Instructions are not fetched from any memory. They arrive from outside, one per clock, and each takes effect at that edge.

The operation set is fixed. There are loads from the input bus, a copy from the accumulator into the general register, stores of either register to the output, and add, OR, AND and complement acting on the accumulator. Software sees results only through the output bus. A short instruction sequence that loads both registers, applies one operation and stores the accumulator can therefore test the arithmetic paths and the instruction decoding.

Top module: `acc_core`

## Requirements
- R1: While rstN is low, the accumulator, the general register and dataOut are all cleared to zero. After reset, dataOut reads 0 until the first store.
- R2: Opcodes 1 and 6 load the accumulator from dataIn. Neither changes the general register.
- R3: Opcode 5 loads the general register from dataIn. Opcode 2 copies the accumulator into the general register. Neither changes the accumulator.
- R4: Opcode 3 writes the general register to dataOut at the clock edge. Opcode 4 writes the accumulator to dataOut. Neither changes either register.
- R5: Opcode 7 sets the accumulator to the sum of the accumulator and the general register, modulo 2^WIDTH.
- R6: Opcode 8 sets the accumulator to the bitwise OR of the accumulator and the general register. Opcode 9 sets it to the bitwise AND.
- R7: Opcode 10 sets the accumulator to its bitwise complement.
- R8: Opcodes 0 and 11 to 15 change no register and leave dataOut unchanged.
- R9: dataOut holds its value across every opcode other than 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opcode | input | 4 | Instruction executed at this edge |
| dataIn | input | WIDTH | Input data bus |
| dataOut | output | WIDTH | Registered output bus |

## Verification
The assertions assume that opcode and dataIn are stable and known at every rising edge. The bench meets this by changing inputs only on falling edges. The assertions also assume that the only way to observe state is through stores. The checks on dataOut look only at the edge after an opcode 3 or 4, or at edges where no store is issued. The bench sweeps all opcodes and a wide range of operand pairs with the default 8-bit width, and drives only the 4-bit opcode field. Every value it drives is therefore a legal instruction.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  typedef enum logic [3:0] {
    OP_NOP0 = 4'd0, OP_LDA = 4'd1, OP_CPR = 4'd2, OP_STR = 4'd3,
    OP_STA = 4'd4, OP_LDR = 4'd5, OP_LDA2 = 4'd6, OP_ADD = 4'd7,
    OP_OR = 4'd8, OP_AND = 4'd9, OP_NOT = 4'd10
  } opcode_e;

  typedef enum logic [2:0] {
    ACC_IN, ACC_ADD, ACC_OR, ACC_AND, ACC_NOT
  } accSrc_e;

  typedef struct packed {
    logic    accWe;
    accSrc_e accSrc;
    logic    regWe;
    logic    regFromIn;
    logic    outWe;
    logic    outFromAcc;
  } ctrl_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{accWe: 1'b0, accSrc: ACC_IN, regWe: 1'b0,
             regFromIn: 1'b0, outWe: 1'b0, outFromAcc: 1'b0};
    case (opcode)
      4'd1, 4'd6: begin ctrl.accWe = 1'b1; ctrl.accSrc = ACC_IN; end
      4'd2:       ctrl.regWe = 1'b1;
      4'd5:       begin ctrl.regWe = 1'b1; ctrl.regFromIn = 1'b1; end
      4'd3:       ctrl.outWe = 1'b1;
      4'd4:       begin ctrl.outWe = 1'b1; ctrl.outFromAcc = 1'b1; end
      4'd7:       begin ctrl.accWe = 1'b1; ctrl.accSrc = ACC_ADD; end
      4'd8:       begin ctrl.accWe = 1'b1; ctrl.accSrc = ACC_OR; end
      4'd9:       begin ctrl.accWe = 1'b1; ctrl.accSrc = ACC_AND; end
      4'd10:      begin ctrl.accWe = 1'b1; ctrl.accSrc = ACC_NOT; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_core_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] accQ, regQ, accNext;

  always_comb begin
    case (ctrl.accSrc)
      ACC_ADD: accNext = accQ + regQ;
      ACC_OR:  accNext = accQ | regQ;
      ACC_AND: accNext = accQ & regQ;
      ACC_NOT: accNext = ~accQ;
      default: accNext = dataIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      regQ    <= '0;
      dataOut <= '0;
    end else begin
      if (ctrl.accWe) accQ <= accNext;
      if (ctrl.regWe) regQ <= ctrl.regFromIn ? dataIn : accQ;
      if (ctrl.outWe) dataOut <= ctrl.outFromAcc ? accQ : regQ;
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  ctrl_t ctrl;

  acc_ctrl u_ctrl (.opcode(opcode), .ctrl(ctrl));

  acc_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       opcode,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] dataOut,
  input logic [WIDTH-1:0] accQ,
  input logic [WIDTH-1:0] regQ
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (dataOut == '0 && accQ == '0 && regQ == '0));
  // R2
  load_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == 4'd1 || opcode == 4'd6) |=> (accQ == $past(dataIn) && $stable(regQ)));
  // R3
  load_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    opcode == 4'd5 |=> (regQ == $past(dataIn) && $stable(accQ)));
  // R4
  store_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    opcode == 4'd4 |=> (dataOut == $past(accQ)));
  // R5
  add_chk: assert property (@(posedge clk) disable iff (!rstN)
    opcode == 4'd7 |=> (accQ == WIDTH'($past(accQ) + $past(regQ))));
  // R7
  not_chk: assert property (@(posedge clk) disable iff (!rstN)
    opcode == 4'd10 |=> (accQ == ~$past(accQ)));
  // R8
  nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == 4'd0 || opcode > 4'd10) |=> ($stable(accQ) && $stable(regQ) && $stable(dataOut)));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opcode != 4'd3 && opcode != 4'd4) |=> $stable(dataOut));
endmodule

bind acc_core acc_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .opcode(opcode), .dataIn(dataIn), .dataOut(dataOut),
  .accQ(u_dpath.accQ), .regQ(u_dpath.regQ)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
  localparam int W = 8;
  logic clk = 0, rstN = 0;
  logic [3:0] opcode = 0;
  logic [W-1:0] dataIn = 0;
  logic [W-1:0] dataOut;
  int tests = 0, fails = 0;

  acc_core #(.WIDTH(W)) u0 (.clk(clk), .rstN(rstN), .opcode(opcode), .dataIn(dataIn), .dataOut(dataOut));

  always #5 clk = ~clk;

  task automatic step(input logic [3:0] op, input logic [W-1:0] d);
    opcode = op; dataIn = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    tests++;
    if (dataOut !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, dataOut, exp);
    end
  endtask

  // run: R <- r, A <- a, op d, store A
  task automatic seq(input logic [3:0] d, input logic [W-1:0] a, input logic [W-1:0] r,
                     input logic [W-1:0] inD);
    step(4'd5, r); step(4'd1, a); step(d, inD); step(4'd4, 8'h00);
  endtask

  function automatic logic [W-1:0] expect_acc(input logic [3:0] d, input logic [W-1:0] a,
                                             input logic [W-1:0] r, input logic [W-1:0] inD);
    case (d)
      4'd1, 4'd6: return inD;
      4'd7: return W'(a + r);
      4'd8: return a | r;
      4'd9: return a & r;
      4'd10: return ~a;
      default: return a;
    endcase
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 8'h00);
    rstN = 1;
    step(4'd0, 8'h55);
    check("R1", 8'h00);
    // R5 adder sweep
    for (int a = 0; a < 256; a += 17)
      for (int r = 0; r < 256; r += 13) begin
        seq(4'd7, a[W-1:0], r[W-1:0], 8'h00);
        check("R5", W'(a + r));
      end
    // conformity sweep over all opcodes: R2 R3 R6 R7 R8
    for (int d = 0; d < 16; d++)
      for (int k = 0; k < 8; k++) begin
        logic [W-1:0] a, r, x;
        a = W'(8'h3C ^ (k * 37)); r = W'(8'hA5 + k * 29); x = W'(8'h5A ^ (k * 71));
        seq(d[3:0], a, r, x);
        if (d == 3 || d == 4) continue;
        check((d == 8 || d == 9) ? "R6" : (d == 10) ? "R7" : (d == 1 || d == 6) ? "R2" :
              (d == 0 || d > 10) ? "R8" : "R3", expect_acc(d[3:0], a, r, x));
      end
    // R3 copy A to R, A unchanged, R observed via store R
    step(4'd5, 8'h11); step(4'd1, 8'hC3); step(4'd2, 8'hFF);
    step(4'd3, 8'h00); check("R3", 8'hC3);
    step(4'd4, 8'h00); check("R3", 8'hC3);
    // R4 store R then R9 hold across non-stores
    step(4'd5, 8'h7E); step(4'd1, 8'h81);
    step(4'd3, 8'h00); check("R4", 8'h7E);
    step(4'd7, 8'h00); check("R9", 8'h7E);
    step(4'd1, 8'h22); check("R9", 8'h7E);
    step(4'd5, 8'h33); check("R9", 8'h7E);
    step(4'd4, 8'h00); check("R4", 8'h22);
    step(4'd3, 8'h00); check("R4", 8'h33);
    // R8 nop keeps R intact
    step(4'd15, 8'hEE); step(4'd3, 8'h00); check("R8", 8'h33);
    // R1 reset mid-run
    rstN = 0; step(4'd0, 8'h00); check("R1", 8'h00);
    rstN = 1; step(4'd4, 8'h00); check("R1", 8'h00);
    step(4'd3, 8'h00); check("R1", 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule